// File: doc/BRIEF.md
# SPI-Addressed Timer Record Slave

This block is an SPI slave, clocked by a fast system clock, that keeps a table of timer records for downstream output-compare logic. Each record is 64 bits wide and is split into a left and a right half. Each half packs three fields: a note, a power value and a pitch-bend value. A master on the SPI bus can write a record, read it, or read it and replace it in the same frame. The master can also send one-byte commands. These select one of four banks, drive two nibbles of an LED output, read back a 4-bit switch input, or return every record to its default. The current bank and a combinational read port into the table are brought out for the output-compare stage, which is not part of this block.

The SPI pins are brought into the system clock through two-flop synchronisers. Clock edges are found by comparing consecutive synchronised samples, so the system clock must run at least four times faster than the SPI clock. The first byte of every frame chooses the frame type from its two top bits and carries an address or a command code in its lower six bits. While the table is being filled with defaults, after a hardware reset or after a soft reset, every frame is ignored.

Top module: `tsr_slave`

## Requirements
- R1: After reset is released, every record reads as the default value 64'h00002000_00002000: note 0, power 0 and pitch-bend 0x2000 in both halves. This fill takes NUM_REC system clock cycles. A frame whose select falls during the fill is ignored completely, including any command it carries.
- R2: SPI uses mode 0: MOSI is sampled on the rising SCK edge, MISO changes after the falling edge, and both are MSB first. First-byte bits [7:6] give the frame type: 00 is record write/exchange, 10 is record read, 01 is command write, 11 is command read. Bits [5:0] carry the record address or the command code.
- R3: A 00 frame is followed by 8 data bytes, first byte most significant: left note, left power, left pitch-bend high 6 bits, left pitch-bend low 8 bits, then the same four fields for the right half. Once the eighth data byte has arrived, the record at the address holds the new value and shows it on rec_data.
- R4: Padding bits are stored as zero. The record is stored as the received data ANDed with 64'h7F7F3FFF_7F7F3FFF.
- R5: A 10 frame shifts the stored record out on MISO during the 8 bytes that follow the header, most significant byte first, and leaves the record unchanged.
- R6: During a 00 frame, MISO carries the old record contents during the 8 data bytes. The new value replaces the old one only when the frame completes.
- R7: If select rises before the eighth data byte of a 00 frame has arrived, the record is left unchanged.
- R8: In a command frame, the MISO byte is {4'b0000, value}. Value is the register chosen by code bits [5:4]: 00 is the bank, 01 the switches, 10 LED[3:0], 11 LED[7:4]. Write command 0001bb sets bank_sel to bb and returns the previous bank. A read command changes nothing.
- R9: Write command 10dddd sets LED[3:0] to dddd and write command 11dddd sets LED[7:4] to dddd. Each returns the previous nibble. Both nibbles are 0 after reset.
- R10: A read with code 01xxxx returns the live switch inputs. A write with code 01xxxx changes no LED, bank or record.
- R11: Write command 000000 returns every record to the default of R1 within NUM_REC cycles, and leaves the bank and the LEDs unchanged.
- R12: MISO is low while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data into the slave |
| spi_miso | output | 1 | SPI data out of the slave |
| sw_in | input | 4 | Switch inputs, asynchronous |
| led_out | output | 8 | LED drive, two command-written nibbles |
| bank_sel | output | 2 | Currently selected bank |
| rec_addr | input | 6 | Downstream record read address |
| rec_data | output | 64 | Record at rec_addr, combinational |

## Verification
A MISO bit is due about three system cycles after the SCK falling edge that produces it: two synchroniser stages, then the shift register. The bench holds each SCK phase for eight system cycles and samples MISO just before raising SCK. An LED, bank or record update lands about three cycles after the SPI rising edge that completes the deciding byte. The bench checks these outputs only after select has risen and eight more cycles have passed. A fill, whether after reset or after a soft reset, takes 64 cycles, so the bench waits 100 cycles before it reads rec_data.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int HDR_W      = 8;
    localparam int DATA_BYTES = 8;
    localparam int REC_W      = DATA_BYTES * 8;
    localparam int NIB_W      = 4;

    // frame type, header bits [7:6]
    localparam logic [1:0] FT_REC_XCHG = 2'b00;
    localparam logic [1:0] FT_CMD_WR   = 2'b01;
    localparam logic [1:0] FT_REC_RD   = 2'b10;
    localparam logic [1:0] FT_CMD_RD   = 2'b11;

    // command register select, code bits [5:4]
    typedef enum logic [1:0] {
        SEL_BANK   = 2'b00,
        SEL_SWITCH = 2'b01,
        SEL_LED_LO = 2'b10,
        SEL_LED_HI = 2'b11
    } reg_sel_e;

    localparam logic [31:0] HALF_DEFAULT = 32'h0000_2000;
    localparam logic [31:0] HALF_MASK    = 32'h7F7F_3FFF;
    localparam logic [REC_W-1:0] REC_DEFAULT = {HALF_DEFAULT, HALF_DEFAULT};
    localparam logic [REC_W-1:0] REC_MASK    = {HALF_MASK, HALF_MASK};

endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/tsr_store.sv
module tsr_store
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REC_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [REC_W-1:0]  ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [REC_W-1:0]  rb_data,
    output logic              busy
);

    localparam int NUM_REC = 1 << ADDR_W;

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] idx;
    } sweep_t;

    sweep_t sw_d, sw_q;
    logic [REC_W-1:0] mem [NUM_REC];

    always_comb begin
        sw_d = sw_q;
        if (soft_rst) begin
            sw_d.busy = 1'b1;
            sw_d.idx  = '0;
        end else if (sw_q.busy) begin
            sw_d.idx = sw_q.idx + 1'b1;
            if (sw_q.idx == ADDR_W'(NUM_REC - 1)) sw_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q.busy <= 1'b1;
            sw_q.idx  <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    always_ff @(posedge clk) begin
        if (sw_q.busy)  mem[sw_q.idx] <= REC_DEFAULT;
        else if (wr_en) mem[wr_addr]  <= wr_data;
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
    assign busy    = sw_q.busy;

    // R1
    no_write_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sw_q.busy);

    // R11
    soft_rst_starts_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> sw_q.busy && (sw_q.idx == '0));

endmodule

// File: rtl/tsr_frame.sv
module tsr_frame
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [NIB_W-1:0]  sw_s,
    input  logic              busy,
    output logic              miso,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [REC_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REC_W-1:0]  wr_data,
    output logic              soft_rst,
    output logic [1:0]        bank,
    output logic [7:0]        led
);

    localparam int BYTE_CNT_W = $clog2(DATA_BYTES + 2);
    localparam logic [BYTE_CNT_W-1:0] BYTE_DONE = BYTE_CNT_W'(DATA_BYTES + 1);
    localparam logic [BYTE_CNT_W-1:0] BYTE_LAST = BYTE_CNT_W'(DATA_BYTES);

    typedef struct packed {
        logic                  sck_prev;
        logic                  cs_prev;
        logic                  active;
        logic [2:0]            bit_cnt;
        logic [BYTE_CNT_W-1:0] byte_cnt;
        logic [6:0]            rx;
        logic [HDR_W-1:0]      hdr;
        logic [REC_W-9:0]      wdata;
        logic [REC_W-1:0]      tx;
        logic [1:0]            bank;
        logic [7:0]            led;
    } frame_t;

    frame_t q, n;
    logic       sck_rise, sck_fall, cs_fall;
    logic [7:0] full_byte;
    logic [NIB_W-1:0] nib;
    logic       cmd_fire;

    always_comb begin
        n         = q;
        wr_en     = 1'b0;
        soft_rst  = 1'b0;
        cmd_fire  = 1'b0;
        full_byte = {q.rx, mosi_s};
        sck_rise  = sck_s & ~q.sck_prev;
        sck_fall  = ~sck_s & q.sck_prev;
        cs_fall   = ~cs_s & q.cs_prev;
        n.sck_prev = sck_s;
        n.cs_prev  = cs_s;

        unique case (reg_sel_e'(q.rx[1:0]))
            SEL_BANK:   nib = {2'b00, q.bank};
            SEL_SWITCH: nib = sw_s;
            SEL_LED_LO: nib = q.led[3:0];
            SEL_LED_HI: nib = q.led[7:4];
        endcase

        if (cs_s || busy) begin
            n.active   = 1'b0;
            n.bit_cnt  = '0;
            n.byte_cnt = '0;
            n.tx       = '0;
        end else if (cs_fall) begin
            n.active   = 1'b1;
            n.bit_cnt  = '0;
            n.byte_cnt = '0;
            n.tx       = '0;
        end else if (q.active) begin
            if (sck_rise) begin
                n.rx      = full_byte[6:0];
                n.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    if (q.byte_cnt != BYTE_DONE) n.byte_cnt = q.byte_cnt + 1'b1;
                    if (q.byte_cnt == '0) begin
                        n.hdr = full_byte;
                        if (full_byte[7:6] == FT_CMD_WR) begin
                            cmd_fire = 1'b1;
                            unique case (reg_sel_e'(full_byte[5:4]))
                                SEL_BANK: begin
                                    if (full_byte[3:2] == 2'b01) n.bank = full_byte[1:0];
                                    else if (full_byte[3:0] == 4'd0) soft_rst = 1'b1;
                                end
                                SEL_SWITCH: ;
                                SEL_LED_LO: n.led[3:0] = full_byte[3:0];
                                SEL_LED_HI: n.led[7:4] = full_byte[3:0];
                            endcase
                        end
                    end else if (q.byte_cnt <= BYTE_LAST) begin
                        n.wdata = {q.wdata[REC_W-17:0], full_byte};
                        if (q.byte_cnt == BYTE_LAST && q.hdr[7:6] == FT_REC_XCHG) wr_en = 1'b1;
                    end
                end
            end else if (sck_fall) begin
                if (q.byte_cnt == '0 && q.bit_cnt == 3'd4) begin
                    n.tx = q.rx[2] ? {nib, {(REC_W-NIB_W){1'b0}}} : '0;
                end else if (q.byte_cnt == 1 && q.bit_cnt == 3'd0) begin
                    n.tx = q.hdr[6] ? '0 : rd_data;
                end else begin
                    n.tx = {q.tx[REC_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign miso    = q.active & q.tx[REC_W-1];
    assign rd_addr = q.hdr[ADDR_W-1:0];
    assign wr_addr = q.hdr[ADDR_W-1:0];
    assign wr_data = {q.wdata, full_byte} & REC_MASK;
    assign bank    = q.bank;
    assign led     = q.led;

    // R12
    miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso);

    // R8
    bank_change_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bank != $past(q.bank)) |-> $past(cmd_fire));

    // R9
    led_change_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.led != $past(q.led)) |-> $past(cmd_fire));

    // R1
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !q.active);

endmodule

// File: rtl/tsr_slave.sv
module tsr_slave
    import tsr_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [3:0]        sw_in,
    output logic [7:0]        led_out,
    output logic [1:0]        bank_sel,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic [REC_W-1:0]  rec_data
);

    logic              cs_s, sck_s, mosi_s;
    logic [NIB_W-1:0]  sw_s;
    logic              busy, wr_en, soft_rst;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [REC_W-1:0]  rd_data, wr_data;

    tsr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_spi_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .dout ({cs_s, sck_s, mosi_s})
    );

    tsr_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sw_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sw_in),
        .dout (sw_s)
    );

    tsr_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sck_s   (sck_s),
        .mosi_s  (mosi_s),
        .sw_s    (sw_s),
        .busy    (busy),
        .miso    (spi_miso),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .soft_rst(soft_rst),
        .bank    (bank_sel),
        .led     (led_out)
    );

    tsr_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (rd_addr),
        .ra_data (rd_data),
        .rb_addr (rec_addr),
        .rb_data (rec_data),
        .busy    (busy)
    );

endmodule

// File: tb/tsr_slave_test.sv
`timescale 1ns/1ps
module tsr_slave_test;

    localparam logic [63:0] DEF = 64'h00002000_00002000;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso;
    logic [3:0] sw = 4'h0;
    logic [7:0] led;
    logic [1:0] bank;
    logic [5:0] raddr = '0;
    logic [63:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tsr_slave uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .sw_in(sw), .led_out(led), .bank_sel(bank),
        .rec_addr(raddr), .rec_data(rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        mosi = 1'b0;
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic command(input logic [7:0] b, output logic [7:0] r);
        frame_begin();
        spi_byte(b, r);
        frame_end();
    endtask

    task automatic rec_frame(input logic [1:0] ft, input logic [5:0] a, input logic [63:0] wr,
                             input int nbytes, output logic [63:0] rd);
        logic [7:0] b;
        rd = '0;
        frame_begin();
        spi_byte({ft, a}, b);
        for (int k = 0; k < nbytes; k++) begin
            spi_byte(wr[63-8*k -: 8], b);
            rd[63-8*k -: 8] = b;
        end
        frame_end();
    endtask

    function automatic logic [63:0] port_read(input logic [5:0] a);
        return 64'h0;
    endfunction

    task automatic peek(input logic [5:0] a, output logic [63:0] v);
        raddr = a;
        wait_clk(1);
        v = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        logic [63:0] v;
        wait_clk(3);
        rst_n = 1'b1;
        // frame starts while the fill is running: must be ignored (R1)
        command(8'h6F, r);
        check("R1 led after frame during fill", {56'h0, led}, 64'h0);
        check("R1 bank after reset", {62'h0, bank}, 64'h0);
        check("R12 miso with select high", {63'h0, miso}, 64'h0);
        wait_clk(100);
        peek(6'd0, v);  check("R1 record 0 default", v, DEF);
        peek(6'd63, v); check("R1 record 63 default", v, DEF);
    endtask

    task automatic t_write_read();
        logic [63:0] rd, v;
        rec_frame(2'b00, 6'd5, 64'h15012000_66771000, 8, rd);
        check("R6 old contents during first write", rd, DEF);
        peek(6'd5, v); check("R3 record 5 after write", v, 64'h15012000_66771000);
        check("R12 miso low after frame", {63'h0, miso}, 64'h0);
        rec_frame(2'b10, 6'd5, 64'h0, 8, rd);
        check("R5 read frame data", rd, 64'h15012000_66771000);
        check("R2 msb first on read", {56'h0, rd[63:56]}, 64'h15);
        peek(6'd5, v); check("R5 record unchanged by read", v, 64'h15012000_66771000);
        peek(6'd6, v); check("R3 neighbour untouched", v, DEF);
    endtask

    task automatic t_padding();
        logic [63:0] rd, v;
        rec_frame(2'b00, 6'd9, 64'hFFFFFFFF_FFFFFFFF, 8, rd);
        peek(6'd9, v); check("R4 padding cleared", v, 64'h7F7F3FFF_7F7F3FFF);
    endtask

    task automatic t_exchange();
        logic [63:0] rd, v;
        rec_frame(2'b00, 6'd5, 64'h381D2000_00002000, 8, rd);
        check("R6 exchange returns old", rd, 64'h15012000_66771000);
        peek(6'd5, v); check("R6 exchange stores new", v, 64'h381D2000_00002000);
    endtask

    task automatic t_partial();
        logic [63:0] rd, v;
        rec_frame(2'b00, 6'd9, 64'h01020304_05060708, 5, rd);
        peek(6'd9, v); check("R7 partial frame discarded", v, 64'h7F7F3FFF_7F7F3FFF);
    endtask

    task automatic t_bank();
        logic [7:0] r;
        command(8'h46, r); check("R8 bank write returns old 0", {56'h0, r}, 64'h00);
        check("R8 bank is 2", {62'h0, bank}, 64'h2);
        command(8'h47, r); check("R8 bank write returns old 2", {56'h0, r}, 64'h02);
        check("R8 bank is 3", {62'h0, bank}, 64'h3);
        command(8'hC5, r); check("R8 bank read returns 3", {56'h0, r}, 64'h03);
        check("R8 bank unchanged by read", {62'h0, bank}, 64'h3);
    endtask

    task automatic t_led();
        logic [7:0] r;
        command(8'h65, r); check("R9 led low write returns old", {56'h0, r}, 64'h00);
        check("R9 led after low write", {56'h0, led}, 64'h05);
        command(8'h7A, r); check("R9 led high write returns old", {56'h0, r}, 64'h00);
        check("R9 led after high write", {56'h0, led}, 64'hA5);
        command(8'hE0, r); check("R9 led low read", {56'h0, r}, 64'h05);
        command(8'hF0, r); check("R9 led high read", {56'h0, r}, 64'h0A);
        command(8'h63, r); check("R9 led low rewrite returns 5", {56'h0, r}, 64'h05);
        check("R9 led after rewrite", {56'h0, led}, 64'hA3);
    endtask

    task automatic t_switch();
        logic [7:0] r;
        sw = 4'b0110; wait_clk(4);
        command(8'hD0, r); check("R10 switch read 0110", {56'h0, r}, 64'h06);
        sw = 4'b1001; wait_clk(4);
        command(8'hD0, r); check("R10 switch read 1001", {56'h0, r}, 64'h09);
        command(8'h53, r); check("R10 switch write returns live", {56'h0, r}, 64'h09);
        check("R10 switch write leaves led", {56'h0, led}, 64'hA3);
        check("R10 switch write leaves bank", {62'h0, bank}, 64'h3);
    endtask

    task automatic t_soft();
        logic [7:0] r;
        logic [63:0] v;
        command(8'h40, r); check("R11 soft reset returns bank", {56'h0, r}, 64'h03);
        wait_clk(100);
        peek(6'd5, v); check("R11 record 5 default", v, DEF);
        peek(6'd9, v); check("R11 record 9 default", v, DEF);
        check("R11 led kept", {56'h0, led}, 64'hA3);
        check("R11 bank kept", {62'h0, bank}, 64'h3);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_padding();
        t_exchange();
        t_partial();
        t_bank();
        t_led();
        t_switch();
        t_soft();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule